// File: doc/BRIEF.md
# Sampling Tap Tuning Window Selector

This block picks the sampling-clock delay tap for a high-speed SD or eMMC card interface. After a start request it walks through twice as many probe slots as there are taps. In each slot it presents a tap index and a probe request to an external tuning engine, then waits for that engine to report whether the tuning transfer at that tap passed.

Once every slot has a result, the block pairs each slot with its partner in the other half of the sweep. A slot survives only if both of its probes passed. The block then scans the surviving slots for the longest unbroken run. If that run is long enough, it commits the tap at the run's centre, folded back into the tap range. It also pulses a request to clear pending correction flags and turns on automatic re-tuning. If the run is too short, it flags a tuning error and leaves the committed tap alone. A tap count of zero means tuning is not supported.

The tap count is supplied at runtime with each start. Eight taps is the usual setting and four is used in the double-data-rate high-speed mode. The most the block accepts is set by a parameter.

Top module: `tap_tune_select`

## Requirements
- R1: After an accepted start with tap count N (1..MAX_TAPS), the block raises `probe_req` for exactly 2N probe slots, one per `probe_done` handshake. During slot i it drives `probe_tap` = i mod N.
- R2: The `probe_pass` value seen with `probe_done` in slot i is recorded as that slot's result. Before the search, slot i is kept only if slot i and its partner slot (i+N for i<N, i−N otherwise) both passed.
- R3: The search finds the longest run of consecutive kept slots over all 2N slots, including a run that ends at the last slot. When two runs share the maximum length, the one starting earlier is used.
- R4: If the longest run is at least MIN_RUN (3) slots, then on completion `tap_set` becomes ((start+end)/2) mod N, `tune_ok` is 1, and `done` pulses for one cycle.
- R5: If the longest run is shorter than MIN_RUN, the completion raises `tune_err`, clears `tune_ok` and leaves `tap_set` at its previous value.
- R6: A start with tap count 0 completes the cycle after start with `unsupported`=1, issues no probe and leaves `tap_set` unchanged.
- R7: A start with tap count above MAX_TAPS completes the cycle after start with `tune_err`=1 and issues no probe.
- R8: `auto_retune_en` is cleared by every accepted start, stays 0 while `busy`, and is set only by a successful completion.
- R9: `clear_corr` is a one-cycle pulse that occurs together with `done` on a successful completion, and never otherwise.
- R10: A `start` while `busy` is ignored: the running sweep continues with its original tap count and outcome.
- R11: While reset is active, and until the next start, `busy`, `done`, `probe_req`, `tune_ok`, `tune_err`, `unsupported`, `auto_retune_en` and `clear_corr` are 0, and `tap_set` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a tuning sweep (taken only when idle) |
| tap_count | input | NUM_W (4) | Number of taps N for this sweep |
| probe_req | output | 1 | A probe at `probe_tap` is wanted |
| probe_tap | output | TAP_W (3) | Tap index for the current probe slot |
| probe_done | input | 1 | The external probe finished this cycle |
| probe_pass | input | 1 | Result of the finished probe (1 = pass) |
| busy | output | 1 | Sweep or search in progress |
| done | output | 1 | One-cycle completion pulse |
| tune_ok | output | 1 | Last completion chose a tap |
| tune_err | output | 1 | Last completion failed (short window or too many taps) |
| unsupported | output | 1 | Last start had a tap count of zero |
| tap_set | output | TAP_W (3) | Committed sampling tap |
| auto_retune_en | output | 1 | Automatic re-tuning enable |
| clear_corr | output | 1 | Pulse: clear pending correction requests |

## Verification
The bench builds the block with MAX_TAPS=8 and MIN_RUN=3, so the scan covers up to sixteen slots. It runs sweeps with eight and with four taps, which brings both the normal and the halved tap range within reach. A tap count of nine exercises the over-limit path and a tap count of zero exercises the not-supported path. The patterns include runs that tie for the maximum length, a run that spans the boundary between the two halves, a run that ends on the last slot, and a tap that fails in only one of its two probes.

// File: rtl/tts_pkg.sv
package tts_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_SCAN  = 2'd2
  } tts_state_e;
endpackage

// File: rtl/tts_rst_sync.sv
module tts_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tts_prober.sv
module tts_prober #(
  parameter int MAX_TAPS = 8,
  localparam int TAP_W  = $clog2(MAX_TAPS),
  localparam int NUM_W  = $clog2(MAX_TAPS + 1),
  localparam int SLOTS  = 2 * MAX_TAPS,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch,
  input  logic              active,
  input  logic [NUM_W-1:0]  n_taps,
  input  logic              probe_done,
  input  logic              probe_pass,
  output logic [TAP_W-1:0]  probe_tap,
  output logic [SLOTS-1:0]  results,
  output logic              last
);
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [TAP_W-1:0]  tap_q, tap_d;
  logic [SLOTS-1:0]  res_q, res_d;
  logic [NUM_W:0]    last_slot;
  logic              tap_wrap;
  logic              step;

  assign last_slot = {n_taps, 1'b0} - (NUM_W + 1)'(1);
  assign tap_wrap  = (NUM_W'(tap_q) == n_taps - NUM_W'(1));
  assign step      = active && probe_done;
  assign last      = step && ((NUM_W + 1)'(slot_q) == last_slot);

  always_comb begin
    slot_d = slot_q;
    tap_d  = tap_q;
    res_d  = res_q;
    if (launch) begin
      slot_d = '0;
      tap_d  = '0;
      res_d  = '0;
    end else if (step) begin
      res_d[slot_q] = probe_pass;
      slot_d        = slot_q + SLOT_W'(1);
      tap_d         = tap_wrap ? '0 : tap_q + TAP_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      tap_q  <= '0;
      res_q  <= '0;
    end else if (launch || step) begin
      slot_q <= slot_d;
      tap_q  <= tap_d;
      res_q  <= res_d;
    end
  end

  assign probe_tap = tap_q;
  assign results   = res_q;

  a_r1_tap_below_count: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (NUM_W'(tap_q) < n_taps));
  a_r1_slot_below_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> ((NUM_W + 1)'(slot_q) <= last_slot));
endmodule

// File: rtl/tts_window.sv
module tts_window #(
  parameter int MAX_TAPS = 8,
  parameter int MIN_RUN  = 3,
  localparam int TAP_W  = $clog2(MAX_TAPS),
  localparam int NUM_W  = $clog2(MAX_TAPS + 1),
  localparam int SLOTS  = 2 * MAX_TAPS,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [NUM_W-1:0]  n_taps,
  input  logic [SLOTS-1:0]  raw,
  output logic              fin,
  output logic              win_ok,
  output logic [TAP_W-1:0]  win_tap
);
  logic [SLOT_W:0]   two_n, n_ext;
  logic [SLOTS-1:0]  ones, valid, merged;
  logic [SLOT_W-1:0] idx_q, idx_d;
  logic [SLOT_W:0]   run_q, run_d, run_new;
  logic [SLOT_W:0]   best_len_q, best_len_d;
  logic [SLOT_W-1:0] best_start_q, best_start_d;
  logic              scanning_q, scanning_d;
  logic              fin_q, fin_d;
  logic              cur_bit, at_end;
  logic [SLOT_W+1:0] twice_mid;
  logic [SLOT_W:0]   mid, folded;

  assign two_n  = (SLOT_W + 1)'({n_taps, 1'b0});
  assign n_ext  = (SLOT_W + 1)'(n_taps);
  assign ones   = '1;
  assign valid  = ~(ones << two_n);
  assign merged = raw & ((raw >> n_taps) | (raw << n_taps)) & valid;

  assign cur_bit = merged[idx_q];
  assign run_new = cur_bit ? run_q + (SLOT_W + 1)'(1) : '0;
  assign at_end  = ((SLOT_W + 1)'(idx_q) == two_n - (SLOT_W + 1)'(1));

  always_comb begin
    idx_d        = idx_q;
    run_d        = run_q;
    best_len_d   = best_len_q;
    best_start_d = best_start_q;
    scanning_d   = scanning_q;
    fin_d        = 1'b0;
    if (go) begin
      idx_d        = '0;
      run_d        = '0;
      best_len_d   = '0;
      best_start_d = '0;
      scanning_d   = 1'b1;
    end else if (scanning_q) begin
      run_d = run_new;
      if (cur_bit && (run_new > best_len_q)) begin
        best_len_d   = run_new;
        best_start_d = idx_q - run_q[SLOT_W-1:0];
      end
      if (at_end) begin
        scanning_d = 1'b0;
        fin_d      = 1'b1;
      end else begin
        idx_d = idx_q + SLOT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q        <= '0;
      run_q        <= '0;
      best_len_q   <= '0;
      best_start_q <= '0;
      scanning_q   <= 1'b0;
      fin_q        <= 1'b0;
    end else begin
      fin_q <= fin_d;
      if (go || scanning_q) begin
        idx_q        <= idx_d;
        run_q        <= run_d;
        best_len_q   <= best_len_d;
        best_start_q <= best_start_d;
        scanning_q   <= scanning_d;
      end
    end
  end

  assign twice_mid = (SLOT_W + 2)'({best_start_q, 1'b0}) + (SLOT_W + 2)'(best_len_q)
                   - (SLOT_W + 2)'(1);
  assign mid       = (SLOT_W + 1)'(twice_mid[SLOT_W+1:1]);
  assign folded    = (mid >= n_ext) ? mid - n_ext : mid;

  assign fin     = fin_q;
  assign win_ok  = (best_len_q >= (SLOT_W + 1)'(MIN_RUN));
  assign win_tap = TAP_W'(folded);

  a_r3_best_fits_sweep: assert property (@(posedge clk) disable iff (!rst_n)
    scanning_q |-> (best_len_q <= two_n));
  a_r3_run_within_index: assert property (@(posedge clk) disable iff (!rst_n)
    scanning_q |-> (run_q <= (SLOT_W + 1)'(idx_q)));
  a_r4_centre_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (fin_q && win_ok) |-> ((SLOT_W + 1)'(win_tap) < n_ext));
endmodule

// File: rtl/tap_tune_select.sv
module tap_tune_select
  import tts_pkg::*;
#(
  parameter int MAX_TAPS = 8,
  parameter int MIN_RUN  = 3,
  localparam int TAP_W  = $clog2(MAX_TAPS),
  localparam int NUM_W  = $clog2(MAX_TAPS + 1),
  localparam int SLOTS  = 2 * MAX_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] tap_count,
  output logic             probe_req,
  output logic [TAP_W-1:0] probe_tap,
  input  logic             probe_done,
  input  logic             probe_pass,
  output logic             busy,
  output logic             done,
  output logic             tune_ok,
  output logic             tune_err,
  output logic             unsupported,
  output logic [TAP_W-1:0] tap_set,
  output logic             auto_retune_en,
  output logic             clear_corr
);
  logic             rst_q_n;
  tts_state_e       state_q, state_d;
  logic [NUM_W-1:0] n_q, n_d;
  logic [TAP_W-1:0] tap_q, tap_d;
  logic             auto_q, auto_d;
  logic             ok_q, ok_d, err_q, err_d, uns_q, uns_d;
  logic             done_q, done_d, clr_q, clr_d;
  logic             launch, win_go;
  logic             probe_last, win_fin, win_ok;
  logic [TAP_W-1:0] win_tap;
  logic [SLOTS-1:0] results;

  tts_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  tts_prober #(.MAX_TAPS(MAX_TAPS)) u_prober (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .launch     (launch),
    .active     (state_q == ST_PROBE),
    .n_taps     (n_q),
    .probe_done (probe_done),
    .probe_pass (probe_pass),
    .probe_tap  (probe_tap),
    .results    (results),
    .last       (probe_last)
  );

  tts_window #(.MAX_TAPS(MAX_TAPS), .MIN_RUN(MIN_RUN)) u_window (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .go      (win_go),
    .n_taps  (n_q),
    .raw     (results),
    .fin     (win_fin),
    .win_ok  (win_ok),
    .win_tap (win_tap)
  );

  always_comb begin
    state_d = state_q;
    n_d     = n_q;
    tap_d   = tap_q;
    auto_d  = auto_q;
    ok_d    = ok_q;
    err_d   = err_q;
    uns_d   = uns_q;
    done_d  = 1'b0;
    clr_d   = 1'b0;
    launch  = 1'b0;
    win_go  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          n_d    = tap_count;
          auto_d = 1'b0;
          ok_d   = 1'b0;
          err_d  = 1'b0;
          uns_d  = 1'b0;
          if (tap_count == '0) begin
            uns_d  = 1'b1;
            done_d = 1'b1;
          end else if (tap_count > NUM_W'(MAX_TAPS)) begin
            err_d  = 1'b1;
            done_d = 1'b1;
          end else begin
            state_d = ST_PROBE;
            launch  = 1'b1;
          end
        end
      end
      ST_PROBE: begin
        if (probe_last) begin
          state_d = ST_SCAN;
          win_go  = 1'b1;
        end
      end
      ST_SCAN: begin
        if (win_fin) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
          if (win_ok) begin
            tap_d  = win_tap;
            auto_d = 1'b1;
            ok_d   = 1'b1;
            clr_d  = 1'b1;
          end else begin
            err_d  = 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      state_q <= ST_IDLE;
      n_q     <= '0;
      tap_q   <= '0;
      auto_q  <= 1'b0;
      ok_q    <= 1'b0;
      err_q   <= 1'b0;
      uns_q   <= 1'b0;
      done_q  <= 1'b0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      n_q     <= n_d;
      tap_q   <= tap_d;
      auto_q  <= auto_d;
      ok_q    <= ok_d;
      err_q   <= err_d;
      uns_q   <= uns_d;
      done_q  <= done_d;
      clr_q   <= clr_d;
    end
  end

  assign probe_req      = (state_q == ST_PROBE);
  assign busy           = (state_q != ST_IDLE);
  assign done           = done_q;
  assign tune_ok        = ok_q;
  assign tune_err       = err_q;
  assign unsupported    = uns_q;
  assign tap_set        = tap_q;
  assign auto_retune_en = auto_q;
  assign clear_corr     = clr_q;

  a_r8_retune_off_while_busy: assert property (@(posedge clk) disable iff (!rst_q_n)
    busy |-> !auto_retune_en);
  a_r9_clear_only_on_success: assert property (@(posedge clk) disable iff (!rst_q_n)
    clear_corr |-> (done && tune_ok));
  a_r5_error_keeps_tap: assert property (@(posedge clk) disable iff (!rst_q_n)
    (done && tune_err) |-> $stable(tap_set));
  a_r6_unsupported_no_probe: assert property (@(posedge clk) disable iff (!rst_q_n)
    unsupported |-> !probe_req);
  a_r4_single_outcome: assert property (@(posedge clk) disable iff (!rst_q_n)
    $onehot0({tune_ok, tune_err, unsupported}));
  a_r10_busy_start_keeps_count: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy && start) |=> $stable(n_q));
endmodule

// File: tb/tap_tune_select_test.sv
module tap_tune_select_test;
  localparam int MAX_TAPS = 8;
  localparam int TAP_W = $clog2(MAX_TAPS);
  localparam int NUM_W = $clog2(MAX_TAPS + 1);
  localparam int NV = 9;

  localparam int          VN  [NV] = '{8, 8, 8, 8, 8, 4, 4, 4, 4};
  localparam logic [15:0] VP  [NV] = '{16'hFFFF, 16'h7C7C, 16'h38FF, 16'h0303,
                                       16'hC3C3, 16'h00FF, 16'h0077, 16'h00BB, 16'h0066};
  localparam bit          VOK [NV] = '{1, 1, 1, 0, 1, 1, 1, 1, 0};
  localparam int          VTAP[NV] = '{7, 4, 4, 0, 7, 3, 1, 0, 0};

  logic clk = 1'b0;
  logic rst_n;
  logic start;
  logic [NUM_W-1:0] tap_count;
  logic probe_req;
  logic [TAP_W-1:0] probe_tap;
  logic probe_done;
  logic probe_pass;
  logic busy, done, tune_ok, tune_err, unsupported, auto_retune_en, clear_corr;
  logic [TAP_W-1:0] tap_set;

  int checks = 0;
  int fails = 0;
  int resp_cnt = 0;
  int tap_bad = 0;
  int auto_bad = 0;
  int cur_n = 1;
  logic [15:0] cur_pat = '0;
  bit finished = 0;
  int last_tap = 0;

  always #4 clk = ~clk;

  tap_tune_select #(.MAX_TAPS(MAX_TAPS), .MIN_RUN(3)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .tap_count(tap_count),
    .probe_req(probe_req), .probe_tap(probe_tap), .probe_done(probe_done),
    .probe_pass(probe_pass), .busy(busy), .done(done), .tune_ok(tune_ok),
    .tune_err(tune_err), .unsupported(unsupported), .tap_set(tap_set),
    .auto_retune_en(auto_retune_en), .clear_corr(clear_corr)
  );

  task automatic chk(input bit good, input string req, input int act, input int exp);
    checks++;
    if (!good) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // probe responder: answers each request one cycle later, then idles a cycle
  initial begin
    probe_done = 1'b0;
    probe_pass = 1'b0;
    forever begin
      @(negedge clk);
      if (busy && auto_retune_en) auto_bad++;
      if (probe_done) begin
        probe_done = 1'b0;
      end else if (probe_req) begin
        if (int'(probe_tap) != resp_cnt % cur_n) tap_bad++;
        probe_pass = cur_pat[resp_cnt % 16];
        probe_done = 1'b1;
        resp_cnt++;
      end
    end
  end

  task automatic tune(input int n, input logic [15:0] pat, input int poke_after);
    cur_n    = (n == 0) ? 1 : n;
    cur_pat  = pat;
    resp_cnt = 0;
    tap_bad  = 0;
    auto_bad = 0;
    @(negedge clk);
    start = 1'b1;
    tap_count = NUM_W'(n);
    @(negedge clk);
    start = 1'b0;
    if (poke_after >= 0) begin
      repeat (poke_after) @(negedge clk);
      start = 1'b1;
      tap_count = NUM_W'(4);
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
  endtask

  task automatic check_result(input string tag, input int n, input bit exp_ok, input int exp_tap);
    chk(resp_cnt == 2 * n && tap_bad == 0, {tag, " R1 probe count/taps"}, resp_cnt + 100 * tap_bad, 2 * n);
    chk(tune_ok == exp_ok && tune_err == !exp_ok, {tag, " R2 R3 outcome"}, int'(tune_ok), int'(exp_ok));
    if (exp_ok) begin
      chk(int'(tap_set) == exp_tap, {tag, " R4 centre tap"}, int'(tap_set), exp_tap);
      last_tap = exp_tap;
    end else begin
      chk(int'(tap_set) == last_tap, {tag, " R5 tap kept on error"}, int'(tap_set), last_tap);
    end
    chk(auto_retune_en == exp_ok && auto_bad == 0, {tag, " R8 auto retune"},
        int'(auto_retune_en) + 10 * auto_bad, int'(exp_ok));
    chk(clear_corr == exp_ok, {tag, " R9 clear pulse with done"}, int'(clear_corr), int'(exp_ok));
    @(negedge clk);
    chk(!done && !clear_corr, {tag, " R9 pulses last one cycle"}, int'(done) + int'(clear_corr), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    start = 1'b0;
    tap_count = '0;
    repeat (4) @(negedge clk);
    // R11: reset state
    chk(!busy && !done && !probe_req && !tune_ok && !tune_err && !unsupported
        && !auto_retune_en && !clear_corr && tap_set == '0, "R11 reset state",
        int'(busy) + int'(probe_req) + int'(tap_set), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && tap_set == '0, "R11 idle after release", int'(busy), 0);

    for (int v = 0; v < NV; v++) begin
      tune(VN[v], VP[v], -1);
      check_result($sformatf("vec%0d", v), VN[v], VOK[v], VTAP[v]);
    end

    // R10: start during a sweep is ignored
    tune(8, 16'h7C7C, 6);
    check_result("busy-start R10", 8, 1'b1, 4);

    // R6: zero taps -> not supported, no probing, tap unchanged, retune cleared
    tune(0, 16'hFFFF, -1);
    chk(unsupported && !tune_ok && !tune_err, "R6 unsupported flag", int'(unsupported), 1);
    chk(resp_cnt == 0, "R6 no probes", resp_cnt, 0);
    chk(int'(tap_set) == last_tap, "R6 tap unchanged", int'(tap_set), last_tap);
    chk(!auto_retune_en, "R8 retune cleared by start", int'(auto_retune_en), 0);

    // R7: too many taps
    tune(9, 16'hFFFF, -1);
    chk(tune_err && !tune_ok && !unsupported, "R7 over-limit error", int'(tune_err), 1);
    chk(resp_cnt == 0, "R7 no probes", resp_cnt, 0);
    chk(int'(tap_set) == last_tap, "R7 tap unchanged", int'(tap_set), last_tap);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule